// File: doc/BRIEF.md
# Boundary-Scan Test Access Port Controller

This block is the serial test port of a chip. A tester clocks it with a test clock and steers it with a mode line, which walks a sixteen-state controller through its instruction and data scan paths. Bits enter on the serial input and leave on the serial output. The output driver is enabled only while a shift is in progress. A four-bit instruction chooses the data register that sits between input and output. That register is one of three: a one-bit pass-through stage, a 32-bit identification word, or a boundary chain whose length is a parameter.

The boundary chain takes a parallel snapshot of the pin values. After each boundary scan its contents move into an update latch vector. That vector feeds the pin drivers and also their per-pin enable cells. For an enable cell, a value of 0 tristates the pin it governs. The block has two mode flags. The first steers the pads to the update latches. The second forces every pad to high impedance. The pads themselves and the mapping of cells to pins are outside this block.

Top module: `scan_tap`

## Requirements
- R1: An active-low `trst_n` asynchronously puts the controller in Test-Logic-Reset. It also clears `tdo_en`, `test_sel`, `out_disable` and every bit of `bsr_upd`, and makes IDCODE the current instruction, all without a clock edge.
- R2: Entering Test-Logic-Reset through five clocks with TMS high, from any state, also makes IDCODE (opcode 0010) the current instruction. A following data scan then returns the identification word.
- R3: In Capture-IR the instruction shift stage loads 4'b1101. It is shifted out least significant bit first, so the output bits are 1, 0, 1, 1.
- R4: The identification word is 32'h2001_A067. Bits 31:28 hold version 2, bits 27:12 hold part 0x001A, bits 11:1 hold maker code 0x033, and bit 0 is 1. It is shifted out least significant bit first.
- R5: EXTEST (0000) and SAMPLE (0001) select the boundary chain. BYPASS (1111) selects a one-bit stage that captures 0, so the output lags the input by one clock.
- R6: Any opcode outside 0000, 0001, 0010, 0011, 1000 and 1111 behaves exactly as BYPASS.
- R7: HIGHZ (0011) selects the bypass stage, sets `out_disable` to 1 and leaves `test_sel` at 0.
- R8: `test_sel` is 1 only under EXTEST (0000) and CLAMP (1000). CLAMP also selects the bypass stage. `out_disable` is 0 under every instruction other than HIGHZ.
- R9: In Capture-DR under EXTEST or SAMPLE, the boundary chain loads `pin_sample`. Cell BSR_LEN-1 lies nearest the output, so the first bit out is `pin_sample[BSR_LEN-1]`, and input bits enter at cell 0.
- R10: `bsr_upd` takes the chain's contents only in Update-DR under EXTEST or SAMPLE. Data scans under any other instruction leave it unchanged.
- R11: `tdo_en` is 1 only while the controller is in Shift-IR or Shift-DR. `tdo` and `tdo_en` change on the falling clock edge, and registers capture and shift on the rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous test reset, active low |
| tms | input | 1 | Mode select, sampled on the rising edge |
| tdi | input | 1 | Serial data in |
| pin_sample | input | BSR_LEN | Parallel pin values captured into the boundary chain |
| tdo | output | 1 | Serial data out, updated on the falling edge |
| tdo_en | output | 1 | Drive enable for tdo |
| test_sel | output | 1 | Pads take their values from bsr_upd |
| out_disable | output | 1 | All pads forced to high impedance |
| bsr_upd | output | BSR_LEN | Boundary update latches for pin data and enable cells |

## Verification
The assertions assume that `tms` and `tdi` settle well before each rising edge of `tck`. They also assume that `trst_n` is pulsed low at least once before the first checked edge, so the state register and the instruction never hold unknown values. The stimulus meets both conditions. It drives `tms`, `tdi` and `pin_sample` one nanosecond after each falling edge. It holds `trst_n` low across the first two clocks. It applies the later asynchronous reset between edges.

// File: rtl/scan_tap_pkg.sv
package scan_tap_pkg;

  typedef enum logic [3:0] {
    ST_RESET, ST_IDLE,
    ST_DSEL, ST_DCAP, ST_DSHF, ST_DEX1, ST_DPAU, ST_DEX2, ST_DUPD,
    ST_ISEL, ST_ICAP, ST_ISHF, ST_IEX1, ST_IPAU, ST_IEX2, ST_IUPD
  } tap_st_e;

  typedef enum logic [2:0] {
    IN_EXTEST, IN_SAMPLE, IN_IDCODE, IN_HIGHZ, IN_CLAMP, IN_BYPASS
  } instr_e;

  localparam int IR_W = 4;
  localparam int ID_W = 32;

  localparam logic [IR_W-1:0] OP_EXTEST = 4'b0000;
  localparam logic [IR_W-1:0] OP_SAMPLE = 4'b0001;
  localparam logic [IR_W-1:0] OP_IDCODE = 4'b0010;
  localparam logic [IR_W-1:0] OP_HIGHZ  = 4'b0011;
  localparam logic [IR_W-1:0] OP_CLAMP  = 4'b1000;
  localparam logic [IR_W-1:0] OP_BYPASS = 4'b1111;
  localparam logic [IR_W-1:0] IR_CAPTURE = 4'b1101;

  function automatic tap_st_e tap_next(input tap_st_e s, input logic m);
    case (s)
      ST_RESET: return m ? ST_RESET : ST_IDLE;
      ST_IDLE:  return m ? ST_DSEL  : ST_IDLE;
      ST_DSEL:  return m ? ST_ISEL  : ST_DCAP;
      ST_DCAP:  return m ? ST_DEX1  : ST_DSHF;
      ST_DSHF:  return m ? ST_DEX1  : ST_DSHF;
      ST_DEX1:  return m ? ST_DUPD  : ST_DPAU;
      ST_DPAU:  return m ? ST_DEX2  : ST_DPAU;
      ST_DEX2:  return m ? ST_DUPD  : ST_DSHF;
      ST_DUPD:  return m ? ST_DSEL  : ST_IDLE;
      ST_ISEL:  return m ? ST_RESET : ST_ICAP;
      ST_ICAP:  return m ? ST_IEX1  : ST_ISHF;
      ST_ISHF:  return m ? ST_IEX1  : ST_ISHF;
      ST_IEX1:  return m ? ST_IUPD  : ST_IPAU;
      ST_IPAU:  return m ? ST_IEX2  : ST_IPAU;
      ST_IEX2:  return m ? ST_IUPD  : ST_ISHF;
      default:  return m ? ST_DSEL  : ST_IDLE;
    endcase
  endfunction

  function automatic instr_e instr_decode(input logic [IR_W-1:0] op);
    case (op)
      OP_EXTEST: return IN_EXTEST;
      OP_SAMPLE: return IN_SAMPLE;
      OP_IDCODE: return IN_IDCODE;
      OP_HIGHZ:  return IN_HIGHZ;
      OP_CLAMP:  return IN_CLAMP;
      default:   return IN_BYPASS;
    endcase
  endfunction

  function automatic logic [ID_W-1:0] id_word(input logic [3:0] ver,
                                              input logic [15:0] part,
                                              input logic [10:0] mfr);
    return {ver, part, mfr, 1'b1};
  endfunction

endpackage

// File: rtl/tap_fsm.sv
module tap_fsm
  import scan_tap_pkg::*;
(
  input  logic    tck,
  input  logic    trst_n,
  input  logic    tms,
  output tap_st_e st
);
  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) st <= ST_RESET;
    else         st <= tap_next(st, tms);
  end
endmodule

// File: rtl/tap_ir.sv
module tap_ir
  import scan_tap_pkg::*;
(
  input  logic            tck,
  input  logic            trst_n,
  input  logic            tdi,
  input  tap_st_e         st,
  output logic [IR_W-1:0] ir_sh,
  output logic [IR_W-1:0] ir_q
);
  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      ir_sh <= IR_CAPTURE;
      ir_q  <= OP_IDCODE;
    end else begin
      if (st == ST_ICAP)      ir_sh <= IR_CAPTURE;
      else if (st == ST_ISHF) ir_sh <= {tdi, ir_sh[IR_W-1:1]};
      if (st == ST_RESET)     ir_q <= OP_IDCODE;
      else if (st == ST_IUPD) ir_q <= ir_sh;
    end
  end
endmodule

// File: rtl/tap_dr.sv
module tap_dr
  import scan_tap_pkg::*;
#(
  parameter int              BSR_LEN = 303,
  parameter logic [ID_W-1:0] ID_VAL  = 32'h2001_A067
) (
  input  logic               tck,
  input  logic               trst_n,
  input  logic               tdi,
  input  tap_st_e            st,
  input  instr_e             instr,
  input  logic [BSR_LEN-1:0] pin_sample,
  output logic               dr_so,
  output logic [BSR_LEN-1:0] bsr_upd
);
  logic               byp_q;
  logic [ID_W-1:0]    id_sh;
  logic [BSR_LEN-1:0] bsr_sh;
  logic [BSR_LEN-1:0] bsr_shifted;
  logic               bsel, isel;

  assign bsel = (instr == IN_EXTEST) || (instr == IN_SAMPLE);
  assign isel = (instr == IN_IDCODE);

  generate
    if (BSR_LEN == 1) begin : g_one
      assign bsr_shifted = tdi;
    end else begin : g_many
      assign bsr_shifted = {bsr_sh[BSR_LEN-2:0], tdi};
    end
  endgenerate

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      byp_q   <= 1'b0;
      id_sh   <= '0;
      bsr_sh  <= '0;
      bsr_upd <= '0;
    end else begin
      case (st)
        ST_DCAP: begin
          byp_q <= 1'b0;
          if (isel) id_sh  <= ID_VAL;
          if (bsel) bsr_sh <= pin_sample;
        end
        ST_DSHF: begin
          if (bsel)      bsr_sh <= bsr_shifted;
          else if (isel) id_sh  <= {tdi, id_sh[ID_W-1:1]};
          else           byp_q  <= tdi;
        end
        ST_DUPD: if (bsel) bsr_upd <= bsr_sh;
        default: ;
      endcase
    end
  end

  always_comb begin
    if (bsel)      dr_so = bsr_sh[BSR_LEN-1];
    else if (isel) dr_so = id_sh[0];
    else           dr_so = byp_q;
  end
endmodule

// File: rtl/scan_tap.sv
module scan_tap #(
  parameter int          BSR_LEN = 303,
  parameter logic [3:0]  ID_VER  = 4'h2,
  parameter logic [15:0] ID_PART = 16'h001A,
  parameter logic [10:0] ID_MFR  = 11'h033
) (
  input  logic               tck,
  input  logic               trst_n,
  input  logic               tms,
  input  logic               tdi,
  input  logic [BSR_LEN-1:0] pin_sample,
  output logic               tdo,
  output logic               tdo_en,
  output logic               test_sel,
  output logic               out_disable,
  output logic [BSR_LEN-1:0] bsr_upd
);
  import scan_tap_pkg::*;

  localparam logic [ID_W-1:0] ID_VAL = id_word(ID_VER, ID_PART, ID_MFR);

  tap_st_e         st;
  logic [IR_W-1:0] ir_sh, ir_q;
  instr_e          instr;
  logic            dr_so;
  logic            in_shift;

  tap_fsm u_fsm (.tck(tck), .trst_n(trst_n), .tms(tms), .st(st));

  tap_ir u_ir (.tck(tck), .trst_n(trst_n), .tdi(tdi), .st(st),
               .ir_sh(ir_sh), .ir_q(ir_q));

  assign instr = instr_decode(ir_q);

  tap_dr #(.BSR_LEN(BSR_LEN), .ID_VAL(ID_VAL)) u_dr (
    .tck(tck), .trst_n(trst_n), .tdi(tdi), .st(st), .instr(instr),
    .pin_sample(pin_sample), .dr_so(dr_so), .bsr_upd(bsr_upd));

  assign in_shift    = (st == ST_DSHF) || (st == ST_ISHF);
  assign test_sel    = (instr == IN_EXTEST) || (instr == IN_CLAMP);
  assign out_disable = (instr == IN_HIGHZ);

  always_ff @(negedge tck or negedge trst_n) begin
    if (!trst_n) begin
      tdo    <= 1'b0;
      tdo_en <= 1'b0;
    end else begin
      tdo_en <= in_shift;
      tdo    <= (st == ST_ISHF) ? ir_sh[0] : dr_so;
    end
  end
endmodule

// File: rtl/scan_tap_chk.sv
module scan_tap_chk
  import scan_tap_pkg::*;
#(
  parameter int BSR_LEN = 303
) (
  input logic               tck,
  input logic               trst_n,
  input logic               tms,
  input tap_st_e            st,
  input logic [3:0]         ir_sh,
  input logic [3:0]         ir_q,
  input logic               tdo_en,
  input logic               test_sel,
  input logic               out_disable,
  input logic [BSR_LEN-1:0] bsr_upd
);
  logic bnd_op;
  assign bnd_op = (ir_q == 4'b0000) || (ir_q == 4'b0001);

  a_r2_reset_loads_idcode: assert property (@(posedge tck) disable iff (!trst_n)
    (st == ST_RESET) |=> (ir_q == 4'b0010));

  a_r2_reset_holds: assert property (@(posedge tck) disable iff (!trst_n)
    (st == ST_RESET && tms) |=> (st == ST_RESET));

  a_r3_capture_pattern: assert property (@(posedge tck) disable iff (!trst_n)
    (st == ST_ICAP) |=> (ir_sh == 4'b1101));

  a_r7_highz_only_disable: assert property (@(posedge tck) disable iff (!trst_n)
    out_disable |-> (!test_sel && ir_q == 4'b0011));

  a_r8_test_sel_ops: assert property (@(posedge tck) disable iff (!trst_n)
    test_sel |-> (ir_q == 4'b0000 || ir_q == 4'b1000));

  a_r10_update_hold: assert property (@(posedge tck) disable iff (!trst_n)
    !(st == ST_DUPD && bnd_op) |=> $stable(bsr_upd));

  a_r11_enable_in_shift: assert property (@(posedge tck) disable iff (!trst_n)
    tdo_en |-> (st == ST_DSHF || st == ST_ISHF));
endmodule

bind scan_tap scan_tap_chk #(.BSR_LEN(BSR_LEN)) u_chk (
  .tck(tck), .trst_n(trst_n), .tms(tms), .st(st), .ir_sh(ir_sh),
  .ir_q(ir_q), .tdo_en(tdo_en), .test_sel(test_sel),
  .out_disable(out_disable), .bsr_upd(bsr_upd));

// File: tb/scan_tap_test.sv
`timescale 1ns/1ps
module scan_tap_test;
  localparam int BL = 12;
  localparam logic [31:0] IDV = 32'h2001_A067;
  localparam logic [BL-1:0] PINS = 12'hA5C;
  localparam int NV = 9;
  // {opcode, test_sel, out_disable, kind: 0 bypass, 1 id, 2 boundary}
  localparam logic [7:0] VEC [NV] = '{
    {4'b0000, 1'b1, 1'b0, 2'd2},
    {4'b0001, 1'b0, 1'b0, 2'd2},
    {4'b0010, 1'b0, 1'b0, 2'd1},
    {4'b0011, 1'b0, 1'b1, 2'd0},
    {4'b1000, 1'b1, 1'b0, 2'd0},
    {4'b1111, 1'b0, 1'b0, 2'd0},
    {4'b0101, 1'b0, 1'b0, 2'd0},
    {4'b1110, 1'b0, 1'b0, 2'd0},
    {4'b0100, 1'b0, 1'b0, 2'd0}
  };

  logic tck = 1'b0, trst_n = 1'b0, tms = 1'b1, tdi = 1'b0;
  logic [BL-1:0] pin_sample = PINS;
  logic tdo, tdo_en, test_sel, out_disable;
  logic [BL-1:0] bsr_upd;
  logic [BL-1:0] exp_upd = '0;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  scan_tap #(.BSR_LEN(BL)) uut (.tck(tck), .trst_n(trst_n), .tms(tms),
    .tdi(tdi), .pin_sample(pin_sample), .tdo(tdo), .tdo_en(tdo_en),
    .test_sel(test_sel), .out_disable(out_disable), .bsr_upd(bsr_upd));

  always #5 tck = ~tck;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input logic m, input logic d, output logic o, output logic e);
    tms = m; tdi = d;
    #3; o = tdo; e = tdo_en;
    @(posedge tck); @(negedge tck); #1;
  endtask

  task automatic shift_ir(input logic [3:0] op, output logic [3:0] cap);
    logic o, e;
    step(1, 0, o, e); step(1, 0, o, e); step(0, 0, o, e); step(0, 0, o, e);
    for (int i = 0; i < 4; i++) begin
      step(i == 3, op[i], o, e);
      cap[i] = o;
    end
    step(1, 0, o, e); step(0, 0, o, e);
  endtask

  task automatic shift_dr(input logic [31:0] din, output logic [31:0] dout, output logic [31:0] ens);
    logic o, e;
    step(1, 0, o, e); step(0, 0, o, e); step(0, 0, o, e);
    for (int i = 0; i < 32; i++) begin
      step(i == 31, din[i], o, e);
      dout[i] = o; ens[i] = e;
    end
    step(1, 0, o, e); step(0, 0, o, e);
  endtask

  function automatic logic [31:0] exp_dr(input logic [1:0] kind, input logic [31:0] din);
    logic [31:0] r;
    if (kind == 2'd1) return IDV;
    if (kind == 2'd0) return {din[30:0], 1'b0};
    for (int i = 0; i < 32; i++)
      r[i] = (i < BL) ? PINS[BL-1-i] : din[i-BL];
    return r;
  endfunction

  initial begin
    #(200_000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic o, e;
    logic [3:0] cap;
    logic [31:0] dout, ens, din;
    @(negedge tck); @(negedge tck); #1;
    // R1 reset state
    check("R1 tdo_en", tdo_en, 0);
    check("R1 test_sel", test_sel, 0);
    check("R1 out_disable", out_disable, 0);
    check("R1 bsr_upd", bsr_upd, 0);
    trst_n = 1;
    step(0, 0, o, e);
    check("R11 tdo_en idle", e, 0);
    // R2/R4: reset instruction is IDCODE
    shift_dr(32'h0, dout, ens);
    check("R4 id word", dout, IDV);
    check("R11 tdo_en shift", ens, 32'hFFFF_FFFF);
    check("R11 tdo_en after", tdo_en, 0);

    for (int v = 0; v < NV; v++) begin
      din = 32'hC3A5_96E1 ^ (32'h1111_1111 * v);
      shift_ir(VEC[v][7:4], cap);
      check("R3 capture 1101", cap, 4'b1101);
      check("R8 test_sel", test_sel, VEC[v][3]);
      check("R7 out_disable", out_disable, VEC[v][2]);
      shift_dr(din, dout, ens);
      check(VEC[v][1:0] == 2'd2 ? "R9 boundary out" :
            VEC[v][1:0] == 2'd1 ? "R4 id out" :
            VEC[v][7:4] inside {4'b0101, 4'b1110, 4'b0100} ? "R6 unknown as bypass" :
            "R5 bypass out", dout, exp_dr(VEC[v][1:0], din));
      if (VEC[v][1:0] == 2'd2)
        for (int k = 0; k < BL; k++) exp_upd[k] = din[31-k];
      check("R10 bsr_upd", bsr_upd, exp_upd);
    end

    // R2: five TMS-high clocks reload IDCODE
    shift_ir(4'b1111, cap);
    for (int i = 0; i < 5; i++) step(1, 0, o, e);
    step(0, 0, o, e);
    shift_dr(32'h5555_AAAA, dout, ens);
    check("R2 idcode after tms reset", dout, IDV);

    // R1: asynchronous reset mid-clock under EXTEST
    shift_ir(4'b0000, cap);
    check("R8 extest test_sel", test_sel, 1);
    #2 trst_n = 0;
    #1;
    check("R1 async test_sel", test_sel, 0);
    check("R1 async bsr_upd", bsr_upd, 0);
    @(negedge tck); #1 trst_n = 1;
    step(0, 0, o, e);
    shift_dr(32'h0, dout, ens);
    check("R1 idcode after trst", dout, IDV);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule